// File: doc/BRIEF.md
# Perspective Projection Unit

This block carries one 3D vertex, or three vertices in sequence, through a fixed-point projection. It first rotates the vertex by a 3x3 matrix and adds a translation, producing three 32-bit accumulator results and three clamped 16-bit intermediates. It then divides a projection distance by the resulting view depth. The quotient is rounded and saturated. Last, it turns that quotient into a pair of screen coordinates and a depth-cue interpolation factor.

Results go into small shift FIFOs for depth and for screen X/Y. Each push drops the oldest entry. The depth-cue factor lands in a single register. Eight sticky flags record every clamp that occurs during one command. A summary bit, the OR of the eight flags, is refreshed when the command finishes.

A command starts on a one-cycle `start` pulse. The `triple` input selects one vertex or three, `shift_en` selects the fractional down-shift and `pos_only` selects the clamp floor. These three mode bits are captured when the command starts. The other operands must be held stable while `busy` is high. The divide is iterative, so a vertex takes about 36 cycles.

Top module: `ppu_top`

## Requirements
- R1: After reset, `busy`, `done`, `flags`, `err`, `ir0`, every FIFO entry, and every `mac` and `ir` element read zero.
- R2: For each row r, `mac[r]` is the low 32 bits of (trans[r]*4096 + sum over c of rot[r][c]*vtx[c]), shifted arithmetically right by 12 when `shift_en`=1 and left unshifted when `shift_en`=0. `ir[r]` is `mac[r]` clamped to -32768..32767, or to 0..32767 when `pos_only`=1. A clamp of row r sets `flags[r]`.
- R3: The depth pushed into `sz_fifo` is mac[2] when `shift_en`=1, or mac[2] shifted arithmetically right by 12 when `shift_en`=0. It is clamped to 0..65535, and a clamp sets `flags[3]`.
- R4: With SZ the pushed depth and h read as unsigned, the quotient is q = floor((floor(h*131072/SZ)+1)/2). If q exceeds 0x1FFFF, or if SZ is 0, q becomes 0x1FFFF and `flags[4]` is set.
- R5: Screen X is the low 32 bits of (q*ir[0] + ofx) shifted arithmetically right by 16. Screen Y is the same with ir[1] and ofy. Each is clamped to -1024..1023, with `flags[5]` (X) and `flags[6]` (Y) set on a clamp. Both are pushed into `sx_fifo` and `sy_fifo` in the same cycle.
- R6: `ir0` is the low 32 bits of (q*dqa + dqb) shifted arithmetically right by 12, clamped to 0..4096. A clamp sets `flags[7]`.
- R7: Each FIFO is 3 entries deep. A push moves entry k+1 into entry k and writes the new value into entry 2, so entry 2 is the newest.
- R8: With `triple`=1 the vertices vtx[0], vtx[1] and vtx[2] are processed in that order. `flags` and `err` are cleared at start, `flags` accumulate across the vertices, and `err` becomes the OR of all eight flags when the command completes.
- R9: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a one-cycle pulse with `busy` low. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command start pulse |
| triple | input | 1 | 1 = three vertices, 0 = vtx[0] only |
| shift_en | input | 1 | Fractional down-shift select |
| pos_only | input | 1 | Clamp intermediates at zero |
| vtx | input | 3x3x16 | Vertices [vertex][axis], signed |
| rot | input | 3x3x16 | Rotation matrix [row][col], signed |
| trans | input | 3x32 | Translation, signed |
| h | input | 16 | Projection distance, unsigned |
| ofx | input | 32 | Screen X offset, signed |
| ofy | input | 32 | Screen Y offset, signed |
| dqa | input | 16 | Depth-cue slope, signed |
| dqb | input | 32 | Depth-cue base, signed |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command complete pulse |
| mac | output | 3x32 | Transform accumulators |
| ir | output | 3x16 | Clamped intermediates |
| sz_fifo | output | 3x16 | Depth FIFO, entry 2 newest |
| sx_fifo | output | 3x16 | Screen X FIFO, entry 2 newest |
| sy_fifo | output | 3x16 | Screen Y FIFO, entry 2 newest |
| ir0 | output | 16 | Depth-cue factor |
| flags | output | 8 | Sticky clamp flags |
| err | output | 1 | Flag summary |

## Verification
The assertions check the handshake on every cycle: `done` lasts one cycle and never coincides with `busy`, and `flags` are zero when `busy` rises. They also check several invariants every cycle:
- a zero depth forces the saturated quotient and its flag;
- each depth push matches the transform result;
- the FIFOs shift on each push;
- screen coordinates and `ir0` stay inside their ranges.

The arithmetic itself can only be shown by the bench's scenarios, which compare against an independent model: rounding of the divide, the `shift_en` and `pos_only` variants, negative-depth clamping, accumulation of flags over three vertices, and an ignored second `start`.

// File: rtl/ppu_pkg.sv
package ppu_pkg;
  typedef enum logic [1:0] {S_IDLE, S_XF, S_DIVW, S_POST} ppu_state_e;
  localparam int FRAC_SH  = 12;
  localparam int DIV_SH   = 17;
  localparam int XY_SH    = 16;
  localparam int QW       = 17;
  localparam int FL_SZ    = 3;
  localparam int FL_DIV   = 4;
  localparam int FL_SX    = 5;
  localparam int FL_SY    = 6;
  localparam int FL_IR0   = 7;
  localparam int NFLAGS   = 8;
endpackage

// File: rtl/ppu_xform.sv
module ppu_xform #(
  parameter int CW   = 16,
  parameter int TW   = 32,
  parameter int MW   = 32,
  parameter int FRAC = 12
) (
  input  logic [2:0][2:0][CW-1:0] rot,
  input  logic [2:0][TW-1:0]      trans,
  input  logic [2:0][CW-1:0]      vec,
  input  logic                    sf,
  input  logic                    lm,
  output logic [2:0][MW-1:0]      mac,
  output logic [2:0][CW-1:0]      ir,
  output logic [2:0]              ir_sat,
  output logic [CW-1:0]           sz,
  output logic                    sz_sat
);
  localparam longint IR_HI = (longint'(1) << (CW-1)) - 1;
  localparam longint IR_LO = -(longint'(1) << (CW-1));
  localparam longint SZ_HI = (longint'(1) << CW) - 1;

  logic signed [63:0] acc, shd, m64, lo, s64;
  logic [MW-1:0]      m_l;
  logic [MW-1:0]      m3;

  always_comb begin
    m3 = '0;
    for (int r = 0; r < 3; r++) begin
      acc = 64'(signed'(trans[r])) <<< FRAC;
      for (int c = 0; c < 3; c++)
        acc = acc + 64'(signed'(rot[r][c])) * 64'(signed'(vec[c]));
      shd = sf ? (acc >>> FRAC) : acc;
      m_l = MW'(shd);
      mac[r] = m_l;
      if (r == 2) m3 = m_l;
      m64 = 64'(signed'(m_l));
      lo  = lm ? 64'sd0 : IR_LO;
      if (m64 > IR_HI) begin
        ir[r] = CW'(IR_HI);
        ir_sat[r] = 1'b1;
      end else if (m64 < lo) begin
        ir[r] = CW'(lo);
        ir_sat[r] = 1'b1;
      end else begin
        ir[r] = CW'(m64);
        ir_sat[r] = 1'b0;
      end
    end
    s64 = sf ? 64'(signed'(m3)) : (64'(signed'(m3)) >>> FRAC);
    if (s64 > SZ_HI) begin
      sz = CW'(SZ_HI);
      sz_sat = 1'b1;
    end else if (s64 < 0) begin
      sz = '0;
      sz_sat = 1'b1;
    end else begin
      sz = CW'(s64);
      sz_sat = 1'b0;
    end
  end
endmodule

// File: rtl/ppu_div.sv
module ppu_div #(
  parameter int NUM_W = 33,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             fin,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic             run_q, run_n, fin_q, fin_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [DEN_W-1:0] rem_q, rem_n;
  logic [NUM_W-1:0] dq_q, dq_n;
  logic [DEN_W:0]   trial, diff;
  logic             ge;

  always_comb begin
    trial = {rem_q, dq_q[NUM_W-1]};
    diff  = trial - {1'b0, den};
    ge    = (trial >= {1'b0, den});
    run_n = run_q;
    cnt_n = cnt_q;
    rem_n = rem_q;
    dq_n  = dq_q;
    fin_n = 1'b0;
    if (go) begin
      run_n = 1'b1;
      cnt_n = CNT_W'(NUM_W);
      rem_n = '0;
      dq_n  = num;
    end else if (run_q) begin
      rem_n = ge ? DEN_W'(diff) : DEN_W'(trial);
      dq_n  = {dq_q[NUM_W-2:0], ge};
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        run_n = 1'b0;
        fin_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      fin_q <= 1'b0;
      cnt_q <= '0;
      rem_q <= '0;
      dq_q  <= '0;
    end else begin
      run_q <= run_n;
      fin_q <= fin_n;
      cnt_q <= cnt_n;
      rem_q <= rem_n;
      dq_q  <= dq_n;
    end
  end

  assign fin = fin_q;
  assign quo = dq_q;

  a_r4_div_fin_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |=> !fin_q);
  a_r4_div_fin_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> !run_q);
endmodule

// File: rtl/ppu_post.sv
module ppu_post #(
  parameter int CW      = 16,
  parameter int MW      = 32,
  parameter int QW      = 17,
  parameter int XY_SH   = 16,
  parameter int DQ_SH   = 12,
  parameter int SXY_LIM = 1024,
  parameter int IR0_LIM = 4096
) (
  input  logic [QW-1:0] q,
  input  logic [CW-1:0] irx,
  input  logic [CW-1:0] iry,
  input  logic [MW-1:0] ofx,
  input  logic [MW-1:0] ofy,
  input  logic [CW-1:0] dqa,
  input  logic [MW-1:0] dqb,
  output logic [CW-1:0] sx,
  output logic [CW-1:0] sy,
  output logic          sx_sat,
  output logic          sy_sat,
  output logic [CW-1:0] ir0,
  output logic          ir0_sat
);
  logic [CW-1:0] ir_in  [2];
  logic [MW-1:0] off_in [2];
  logic [CW-1:0] sc     [2];
  logic          sc_sat [2];
  logic signed [63:0] qs;

  assign ir_in[0]  = irx;
  assign ir_in[1]  = iry;
  assign off_in[0] = ofx;
  assign off_in[1] = ofy;
  assign qs        = $signed(64'(q));

  for (genvar a = 0; a < 2; a++) begin : g_axis
    logic signed [63:0] prod, m64;
    always_comb begin
      prod = qs * 64'(signed'(ir_in[a])) + 64'(signed'(off_in[a]));
      m64  = 64'(signed'(MW'(prod >>> XY_SH)));
      if (m64 > 64'(SXY_LIM - 1)) begin
        sc[a] = CW'(SXY_LIM - 1);
        sc_sat[a] = 1'b1;
      end else if (m64 < -64'(SXY_LIM)) begin
        sc[a] = CW'(-SXY_LIM);
        sc_sat[a] = 1'b1;
      end else begin
        sc[a] = CW'(m64);
        sc_sat[a] = 1'b0;
      end
    end
  end

  assign sx     = sc[0];
  assign sy     = sc[1];
  assign sx_sat = sc_sat[0];
  assign sy_sat = sc_sat[1];

  logic signed [63:0] dprod, d64;
  always_comb begin
    dprod = qs * 64'(signed'(dqa)) + 64'(signed'(dqb));
    d64   = 64'(signed'(MW'(dprod >>> DQ_SH)));
    if (d64 > 64'(IR0_LIM)) begin
      ir0 = CW'(IR0_LIM);
      ir0_sat = 1'b1;
    end else if (d64 < 0) begin
      ir0 = '0;
      ir0_sat = 1'b1;
    end else begin
      ir0 = CW'(d64);
      ir0_sat = 1'b0;
    end
  end
endmodule

// File: rtl/ppu_top.sv
module ppu_top
  import ppu_pkg::*;
#(
  parameter int CW    = 16,
  parameter int TW    = 32,
  parameter int MW    = 32,
  parameter int DEPTH = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    triple,
  input  logic                    shift_en,
  input  logic                    pos_only,
  input  logic [2:0][2:0][CW-1:0] vtx,
  input  logic [2:0][2:0][CW-1:0] rot,
  input  logic [2:0][TW-1:0]      trans,
  input  logic [CW-1:0]           h,
  input  logic [MW-1:0]           ofx,
  input  logic [MW-1:0]           ofy,
  input  logic [CW-1:0]           dqa,
  input  logic [MW-1:0]           dqb,
  output logic                    busy,
  output logic                    done,
  output logic [2:0][MW-1:0]      mac,
  output logic [2:0][CW-1:0]      ir,
  output logic [DEPTH-1:0][CW-1:0] sz_fifo,
  output logic [DEPTH-1:0][CW-1:0] sx_fifo,
  output logic [DEPTH-1:0][CW-1:0] sy_fifo,
  output logic [CW-1:0]           ir0,
  output logic [NFLAGS-1:0]       flags,
  output logic                    err
);
  localparam int          NUM_W   = CW + DIV_SH;
  localparam logic [QW-1:0] Q_MAX = {QW{1'b1}};
  localparam int          IR0_LIM = 1 << FRAC_SH;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  ppu_state_e st_q, st_n;
  logic [1:0] vidx_q, vidx_n;
  logic       trip_q, trip_n, sf_q, sf_n, lm_q, lm_n, done_q, done_n, err_q, err_n;
  logic [2:0][MW-1:0]       mac_q, mac_n;
  logic [2:0][CW-1:0]       ir_q, ir_n;
  logic [DEPTH-1:0][CW-1:0] szf_q, szf_n, sxf_q, sxf_n, syf_q, syf_n;
  logic [CW-1:0]            ir0_q, ir0_n;
  logic [NFLAGS-1:0]        fl_q, fl_n;
  logic [QW-1:0]            q_q, q_n;

  logic [2:0][MW-1:0] xf_mac;
  logic [2:0][CW-1:0] xf_ir;
  logic [2:0]         xf_irs;
  logic [CW-1:0]      xf_sz;
  logic               xf_szs;

  ppu_xform #(.CW(CW), .TW(TW), .MW(MW), .FRAC(FRAC_SH)) u_xform (
    .rot(rot), .trans(trans), .vec(vtx[vidx_q]), .sf(sf_q), .lm(lm_q),
    .mac(xf_mac), .ir(xf_ir), .ir_sat(xf_irs), .sz(xf_sz), .sz_sat(xf_szs));

  logic             div_go, div_fin;
  logic [NUM_W-1:0] div_quo;
  logic [NUM_W:0]   rnd;

  ppu_div #(.NUM_W(NUM_W), .DEN_W(CW)) u_div (
    .clk(clk), .rst_n(rst_s), .go(div_go), .num(NUM_W'(h) << DIV_SH),
    .den(xf_sz), .fin(div_fin), .quo(div_quo));

  logic [CW-1:0] pp_sx, pp_sy, pp_ir0;
  logic          pp_sxs, pp_sys, pp_ir0s;

  ppu_post #(.CW(CW), .MW(MW), .QW(QW), .XY_SH(XY_SH), .DQ_SH(FRAC_SH),
             .SXY_LIM(1024), .IR0_LIM(IR0_LIM)) u_post (
    .q(q_q), .irx(ir_q[0]), .iry(ir_q[1]), .ofx(ofx), .ofy(ofy), .dqa(dqa), .dqb(dqb),
    .sx(pp_sx), .sy(pp_sy), .sx_sat(pp_sxs), .sy_sat(pp_sys),
    .ir0(pp_ir0), .ir0_sat(pp_ir0s));

  always_comb begin
    st_n = st_q; vidx_n = vidx_q; trip_n = trip_q; sf_n = sf_q; lm_n = lm_q;
    mac_n = mac_q; ir_n = ir_q; szf_n = szf_q; sxf_n = sxf_q; syf_n = syf_q;
    ir0_n = ir0_q; fl_n = fl_q; q_n = q_q; err_n = err_q; done_n = 1'b0;
    div_go = 1'b0;
    rnd = ({1'b0, div_quo} + 1'b1) >> 1;
    case (st_q)
      S_IDLE: if (start) begin
        st_n = S_XF; vidx_n = '0; trip_n = triple; sf_n = shift_en; lm_n = pos_only;
        fl_n = '0; err_n = 1'b0;
      end
      S_XF: begin
        mac_n = xf_mac;
        ir_n  = xf_ir;
        for (int k = 0; k < DEPTH - 1; k++) szf_n[k] = szf_q[k+1];
        szf_n[DEPTH-1] = xf_sz;
        fl_n[2:0]   = fl_q[2:0] | xf_irs;
        fl_n[FL_SZ] = fl_q[FL_SZ] | xf_szs;
        if (xf_sz == '0) begin
          q_n = Q_MAX;
          fl_n[FL_DIV] = 1'b1;
          st_n = S_POST;
        end else begin
          div_go = 1'b1;
          st_n = S_DIVW;
        end
      end
      S_DIVW: if (div_fin) begin
        if (rnd > (NUM_W+1)'(Q_MAX)) begin
          q_n = Q_MAX;
          fl_n[FL_DIV] = 1'b1;
        end else begin
          q_n = QW'(rnd);
        end
        st_n = S_POST;
      end
      default: begin
        for (int k = 0; k < DEPTH - 1; k++) begin
          sxf_n[k] = sxf_q[k+1];
          syf_n[k] = syf_q[k+1];
        end
        sxf_n[DEPTH-1] = pp_sx;
        syf_n[DEPTH-1] = pp_sy;
        ir0_n = pp_ir0;
        fl_n[FL_SX]  = fl_q[FL_SX]  | pp_sxs;
        fl_n[FL_SY]  = fl_q[FL_SY]  | pp_sys;
        fl_n[FL_IR0] = fl_q[FL_IR0] | pp_ir0s;
        if (!trip_q || vidx_q == 2'd2) begin
          st_n = S_IDLE;
          done_n = 1'b1;
          err_n = |fl_n;
        end else begin
          vidx_n = vidx_q + 1'b1;
          st_n = S_XF;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q <= S_IDLE; vidx_q <= '0; trip_q <= 1'b0; sf_q <= 1'b0; lm_q <= 1'b0;
      mac_q <= '0; ir_q <= '0; szf_q <= '0; sxf_q <= '0; syf_q <= '0;
      ir0_q <= '0; fl_q <= '0; q_q <= '0; err_q <= 1'b0; done_q <= 1'b0;
    end else begin
      st_q <= st_n; vidx_q <= vidx_n; trip_q <= trip_n; sf_q <= sf_n; lm_q <= lm_n;
      mac_q <= mac_n; ir_q <= ir_n; szf_q <= szf_n; sxf_q <= sxf_n; syf_q <= syf_n;
      ir0_q <= ir0_n; fl_q <= fl_n; q_q <= q_n; err_q <= err_n; done_q <= done_n;
    end
  end

  assign busy    = (st_q != S_IDLE);
  assign done    = done_q;
  assign mac     = mac_q;
  assign ir      = ir_q;
  assign sz_fifo = szf_q;
  assign sx_fifo = sxf_q;
  assign sy_fifo = syf_q;
  assign ir0     = ir0_q;
  assign flags   = fl_q;
  assign err     = err_q;

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> !busy);
  a_r8_flags_clear: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(busy) |-> (flags == '0));
  a_r4_zero_depth: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == S_XF && xf_sz == '0) |=> (q_q == Q_MAX && flags[FL_DIV]));
  a_r3_sz_push: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == S_XF) |=> (sz_fifo[DEPTH-1] == $past(xf_sz)));
  a_r6_ir0_range: assert property (@(posedge clk) disable iff (!rst_s)
    ir0 <= CW'(IR0_LIM));

  for (genvar k = 0; k < DEPTH; k++) begin : g_chk
    a_r5_sxy_range: assert property (@(posedge clk) disable iff (!rst_s)
      ($signed(sx_fifo[k]) >= -16'sd1024 && $signed(sx_fifo[k]) <= 16'sd1023 &&
       $signed(sy_fifo[k]) >= -16'sd1024 && $signed(sy_fifo[k]) <= 16'sd1023));
    if (k < DEPTH - 1) begin : g_sh
      a_r7_fifo_shift: assert property (@(posedge clk) disable iff (!rst_s)
        (st_q == S_POST) |=> (sx_fifo[k] == $past(sx_fifo[k+1])));
    end
  end
endmodule

// File: tb/ppu_top_bench.sv
module ppu_top_bench;
  logic clk = 1'b0;
  always #2ns clk = ~clk;

  logic rst_n, start, triple, shift_en, pos_only;
  logic [2:0][2:0][15:0] b_vtx, b_rot;
  logic [2:0][31:0] b_trans;
  logic [15:0] b_h, b_dqa;
  logic [31:0] b_ofx, b_ofy, b_dqb;
  logic busy, done, err;
  logic [2:0][31:0] d_mac;
  logic [2:0][15:0] d_ir, d_sz, d_sx, d_sy;
  logic [15:0] d_ir0;
  logic [7:0] d_flags;

  ppu_top u_ppu_top (
    .clk(clk), .rst_n(rst_n), .start(start), .triple(triple), .shift_en(shift_en),
    .pos_only(pos_only), .vtx(b_vtx), .rot(b_rot), .trans(b_trans), .h(b_h),
    .ofx(b_ofx), .ofy(b_ofy), .dqa(b_dqa), .dqb(b_dqb), .busy(busy), .done(done),
    .mac(d_mac), .ir(d_ir), .sz_fifo(d_sz), .sx_fifo(d_sx), .sy_fifo(d_sy),
    .ir0(d_ir0), .flags(d_flags), .err(err));

  int n_chk = 0, n_err = 0;
  int e_mac[3], e_ir[3], e_sz[3], e_sx[3], e_sy[3], e_ir0, e_flags;
  bit e_err;

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int srnd(int span);
    return int'($urandom_range(2 * span, 0)) - span;
  endfunction

  function automatic longint clampv(longint v, longint lo, longint hi, int bitn);
    if (v > hi) begin e_flags |= (1 << bitn); return hi; end
    if (v < lo) begin e_flags |= (1 << bitn); return lo; end
    return v;
  endfunction

  // reference model of one vertex (R2..R7)
  function automatic void model_vertex(int vi, bit sfv, bit lmv);
    longint acc, q, quot, v;
    int m[3];
    int szv;
    for (int r = 0; r < 3; r++) begin
      acc = longint'($signed(b_trans[r])) <<< 12;
      for (int c = 0; c < 3; c++)
        acc += longint'($signed(b_rot[r][c])) * longint'($signed(b_vtx[vi][c]));
      if (sfv) acc = acc >>> 12;
      m[r] = int'(acc);
      e_mac[r] = m[r];
      e_ir[r] = int'(clampv(longint'(m[r]), lmv ? 0 : -32768, 32767, r));
    end
    szv = int'(clampv(longint'(sfv ? m[2] : (m[2] >>> 12)), 0, 65535, 3));
    e_sz[0] = e_sz[1]; e_sz[1] = e_sz[2]; e_sz[2] = szv;
    if (szv == 0) begin
      q = 131071; e_flags |= 16;
    end else begin
      quot = (longint'(b_h) <<< 17) / longint'(szv);
      q = (quot + 1) / 2;
      if (q > 131071) begin q = 131071; e_flags |= 16; end
    end
    v = q * longint'(e_ir[0]) + longint'($signed(b_ofx));
    e_sx[0] = e_sx[1]; e_sx[1] = e_sx[2];
    e_sx[2] = int'(clampv(longint'(int'(v >>> 16)), -1024, 1023, 5));
    v = q * longint'(e_ir[1]) + longint'($signed(b_ofy));
    e_sy[0] = e_sy[1]; e_sy[1] = e_sy[2];
    e_sy[2] = int'(clampv(longint'(int'(v >>> 16)), -1024, 1023, 6));
    v = q * longint'($signed(b_dqa)) + longint'($signed(b_dqb));
    e_ir0 = int'(clampv(longint'(int'(v >>> 12)), 0, 4096, 7));
  endfunction

  task automatic compare_all(string tag);
    for (int r = 0; r < 3; r++) begin
      check("R2", {tag, " mac"}, longint'($signed(d_mac[r])), longint'(e_mac[r]));
      check("R2", {tag, " ir"}, longint'($signed(d_ir[r])), longint'(e_ir[r]));
    end
    for (int k = 0; k < 3; k++) begin
      check("R3/R7", {tag, " sz_fifo"}, longint'(d_sz[k]), longint'(e_sz[k]));
      check("R5/R7", {tag, " sx_fifo"}, longint'($signed(d_sx[k])), longint'(e_sx[k]));
      check("R5/R7", {tag, " sy_fifo"}, longint'($signed(d_sy[k])), longint'(e_sy[k]));
    end
    check("R6", {tag, " ir0"}, longint'(d_ir0), longint'(e_ir0));
    check("R8", {tag, " flags"}, longint'(d_flags), longint'(e_flags));
    check("R8", {tag, " err"}, longint'(err), longint'(e_err));
  endtask

  task automatic run_cmd(string tag, bit trip, bit sfv, bit lmv, bit poke);
    bit seen = 1'b0;
    @(negedge clk);
    triple = trip; shift_en = sfv; pos_only = lmv; start = 1'b1;
    @(negedge clk);
    start = poke;
    check("R9", {tag, " busy after start"}, longint'(busy), 1);
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
    if (!seen) begin
      n_chk++; n_err++;
      $display("FAIL R9 %s watchdog: actual=0 expected=1", tag);
      return;
    end
    e_flags = 0;
    for (int vi = 0; vi < (trip ? 3 : 1); vi++) model_vertex(vi, sfv, lmv);
    e_err = (e_flags != 0);
    check("R9", {tag, " busy at done"}, longint'(busy), 0);
    compare_all(tag);
    @(negedge clk);
    check("R9", {tag, " done one cycle"}, longint'(done), 0);
  endtask

  task automatic set_ident();
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++) b_rot[r][c] = (r == c) ? 16'h1000 : 16'h0000;
    b_trans = '0; b_ofx = '0; b_ofy = '0; b_dqa = 16'd0; b_dqb = 32'd0;
  endtask

  task automatic rand_ops();
    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < 3; c++) b_rot[r][c] = 16'(srnd(4096));
      b_trans[r] = (r == 2) ? 32'($urandom_range(6000, 0)) : 32'(srnd(3000));
    end
    for (int vi = 0; vi < 3; vi++)
      for (int a = 0; a < 3; a++) b_vtx[vi][a] = 16'(srnd(800));
    b_h = 16'($urandom_range(65535, 0));
    b_ofx = 32'(srnd(1 << 25)); b_ofy = 32'(srnd(1 << 25));
    b_dqa = 16'(srnd(32767)); b_dqb = 32'(srnd(1 << 24));
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; start = 1'b0; triple = 1'b0; shift_en = 1'b0; pos_only = 1'b0;
    b_vtx = '0; b_rot = '0; b_trans = '0; b_h = '0;
    b_ofx = '0; b_ofy = '0; b_dqa = '0; b_dqb = '0;
    for (int k = 0; k < 3; k++) begin
      e_mac[k] = 0; e_ir[k] = 0; e_sz[k] = 0; e_sx[k] = 0; e_sy[k] = 0;
    end
    e_ir0 = 0; e_flags = 0; e_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1", "busy", longint'(busy), 0);
    check("R1", "done", longint'(done), 0);
    compare_all("R1 reset");

    // R2/R4/R5 nominal projection with identity rotation
    set_ident();
    b_vtx[0][0] = 16'd100; b_vtx[0][1] = -16'sd50; b_vtx[0][2] = 16'd200;
    b_trans[2] = 32'd1000; b_h = 16'd200;
    b_dqa = -16'sd300; b_dqb = 32'h0100_0000;
    run_cmd("nominal", 1'b0, 1'b1, 1'b0, 1'b0);

    // R4 zero depth forces saturated quotient
    set_ident();
    b_vtx[0][2] = 16'd0; b_h = 16'd1000;
    run_cmd("R4 zero depth", 1'b0, 1'b1, 1'b0, 1'b0);

    // R4 tiny depth overflows the quotient
    set_ident();
    b_vtx[0][0] = 16'd3; b_trans[2] = 32'd1; b_h = 16'hFFFF;
    run_cmd("R4 overflow", 1'b0, 1'b1, 1'b0, 1'b0);

    // R2 floor clamp with pos_only, R3 negative depth clamp
    set_ident();
    b_vtx[0][0] = -16'sd400; b_vtx[0][1] = 16'd20; b_vtx[0][2] = -16'sd30; b_h = 16'd50;
    run_cmd("R2 pos_only", 1'b0, 1'b1, 1'b1, 1'b0);

    // R2/R3 unshifted mode with large values
    set_ident();
    b_vtx[0][0] = 16'd7; b_vtx[0][2] = 16'd9; b_trans[2] = 32'd3; b_h = 16'd4000;
    run_cmd("R3 unshifted", 1'b0, 1'b0, 1'b0, 1'b0);

    // R5/R6 screen and depth clamps
    set_ident();
    b_vtx[0][2] = 16'd100; b_trans[2] = 32'd100; b_h = 16'd1000;
    b_ofx = 32'h7000_0000; b_ofy = 32'h9000_0000;
    b_dqa = 16'h7FFF; b_dqb = 32'h0;
    run_cmd("R5/R6 clamps", 1'b0, 1'b1, 1'b0, 1'b0);

    // R7/R8/R9 triple with an ignored second start
    set_ident();
    for (int vi = 0; vi < 3; vi++) begin
      b_vtx[vi][0] = 16'(10 * (vi + 1)); b_vtx[vi][1] = 16'(-5 * vi);
      b_vtx[vi][2] = 16'(100 * (vi + 1));
    end
    b_trans[2] = 32'd500; b_h = 16'd300; b_dqa = 16'd100; b_dqb = 32'd4096;
    run_cmd("R8 triple", 1'b1, 1'b1, 1'b0, 1'b1);

    // R8 flags cleared at next command
    run_cmd("R8 reclear", 1'b0, 1'b1, 1'b0, 1'b0);

    for (int n = 0; n < 40; n++) begin
      rand_ops();
      run_cmd("random", 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
              1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule